// File: doc/BRIEF.md
# BCD Time-of-Day Clock Core

This core keeps the time of day in packed BCD as hours, minutes and seconds on a 24-hour cycle. Everything runs on one synchronous system clock. A one-cycle `sec_tick` pulse, made elsewhere, is the only thing that moves time forward. The seconds, minutes and hours fields are chained counters. Each field steps its units digit through 0..9 and its tens digit up to the field's limit. The count 23:59:59 is followed by 00:00:00.

Two active-low set inputs let a user adjust the time by hand. While `min_set_n` is held low, minutes step once per tick and never carry into hours. While `hr_set_n` is held low, hours step once per tick. Seconds keep running in both cases. An active-low clear `clr_n` zeroes the time. A chime output marks each full hour that is reached by normal counting and stays high for a fixed number of seconds. The core is meant to sit between a one-second tick source and a display driver. Digit scanning, segment decoding and button debouncing are outside this block.

Top module: `tod_bcd_clock`

## Requirements
- R1: Asserting `rst_n` low (asynchronous) or holding `clr_n` low at a clock edge (synchronous, with priority over `sec_tick`) makes all three fields 00 and drives `chime` low. After the clear, the next tick gives 00:00:01.
- R2: On a clock edge where `sec_tick` is low, no output changes.
- R3: Each tick advances seconds by one in BCD. The step x9 goes to (x+1)0, and 59 goes to 00 with a carry into minutes.
- R4: On normal counting, minutes roll 59→00 and advance hours. Hours roll 23→00, so 23:59:59 is followed by 00:00:00.
- R5: Encoding: `sec_bcd` and `min_bcd` hold the tens digit in bits [6:4] and the units digit in bits [3:0]. `hr_bcd` holds tens in [5:4] and units in [3:0]. The digits never leave their legal range (seconds and minutes ≤ 59, hours ≤ 23).
- R6: While `min_set_n` is low, each tick advances minutes by exactly one, wrapping 59→00. Minutes do not carry into hours, and seconds keep counting.
- R7: While `hr_set_n` is low, each tick advances hours by one (including 09→10 and 23→00). Seconds keep counting.
- R8: When a tick with `min_set_n` high takes minutes and seconds from 59:59 to 00:00, `chime` goes high on that same edge. It stays high for exactly `CHIME_SECS` (default 5) ticks and falls with the tick that makes seconds 05.
- R9: A minute rollover produced by `min_set_n` never raises `chime`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low time clear |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| min_set_n | input | 1 | Active-low manual minute advance |
| hr_set_n | input | 1 | Active-low manual hour advance |
| sec_bcd | output | 7 | Seconds, packed BCD |
| min_bcd | output | 7 | Minutes, packed BCD |
| hr_bcd | output | 6 | Hours, packed BCD |
| chime | output | 1 | Full-hour chime window |

## Verification
The bench first runs plain tick streams. These show the units-digit step (09→10) apart from the field wraps (59→00), and tick-free idle cycles confirm that nothing moves without a tick. Held set inputs then drive minutes and hours through their own wraps. This shows whether a set-driven rollover wrongly carries into hours or wrongly starts the chime, and whether seconds keep running. A run across 23:59:59 and an hourly crossing in mid-day separate the chime timing and its length from the rollover itself. A clear issued during an active chime, together with a tick, checks that clear takes priority.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int UNITS_W    = 4;
  localparam int SEC_TENS_W = 3;
  localparam int HR_TENS_W  = 2;

  // next value of a decimal units digit
  function automatic logic [UNITS_W-1:0] units_after(input logic [UNITS_W-1:0] u);
    return (u == UNITS_W'(9)) ? '0 : u + 1'b1;
  endfunction

  // units digit hands a carry to the tens digit
  function automatic logic units_carry(input logic [UNITS_W-1:0] u);
    return u == UNITS_W'(9);
  endfunction

endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr #(
  parameter int TENS_W    = 3,
  parameter int TOP_TENS  = 5,
  parameter int TOP_UNITS = 9,
  localparam int VW       = TENS_W + tod_pkg::UNITS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [VW-1:0] value,
  output logic          at_top
);
  import tod_pkg::*;

  logic [TENS_W-1:0]  tens;
  logic [UNITS_W-1:0] units;

  assign at_top = (tens == TENS_W'(TOP_TENS)) && (units == UNITS_W'(TOP_UNITS));
  assign value  = {tens, units};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens  <= '0;
      units <= '0;
    end else if (clr) begin
      tens  <= '0;
      units <= '0;
    end else if (step) begin
      if (at_top) begin
        tens  <= '0;
        units <= '0;
      end else begin
        units <= units_after(units);
        if (units_carry(units)) tens <= tens + 1'b1;
      end
    end
  end

endmodule

// File: rtl/chime_timer.sv
module chime_timer #(
  parameter int SECS = 5,
  localparam int CW  = $clog2(SECS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic start,
  output logic chime
);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      left <= '0;
    else if (clr)                    left <= '0;
    else if (tick && start)          left <= CW'(SECS);
    else if (tick && left != '0)     left <= left - 1'b1;
  end

  assign chime = (left != '0);

endmodule

// File: rtl/tod_bcd_clock.sv
module tod_bcd_clock #(
  parameter int CHIME_SECS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_n,
  input  logic       sec_tick,
  input  logic       min_set_n,
  input  logic       hr_set_n,
  output logic [6:0] sec_bcd,
  output logic [6:0] min_bcd,
  output logic [5:0] hr_bcd,
  output logic       chime
);
  import tod_pkg::*;

  logic clr;
  logic sec_at_top, min_at_top, hr_at_top;
  logic sec_wrap, min_step, min_carry, hr_step, chime_start;

  assign clr = ~clr_n;

  // event wires, also observed by the checker
  assign sec_wrap    = sec_tick & sec_at_top;
  assign min_step    = sec_tick & (~min_set_n | sec_at_top);
  assign min_carry   = sec_wrap & min_set_n & min_at_top;
  assign hr_step     = (sec_tick & ~hr_set_n) | min_carry;
  assign chime_start = min_carry;

  bcd_field_ctr #(.TENS_W(SEC_TENS_W), .TOP_TENS(5), .TOP_UNITS(9)) u_sec (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(sec_tick),
    .value(sec_bcd), .at_top(sec_at_top));

  bcd_field_ctr #(.TENS_W(SEC_TENS_W), .TOP_TENS(5), .TOP_UNITS(9)) u_min (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(min_step),
    .value(min_bcd), .at_top(min_at_top));

  bcd_field_ctr #(.TENS_W(HR_TENS_W), .TOP_TENS(2), .TOP_UNITS(3)) u_hr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(hr_step),
    .value(hr_bcd), .at_top(hr_at_top));

  chime_timer #(.SECS(CHIME_SECS)) u_chime (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(sec_tick),
    .start(chime_start), .chime(chime));

endmodule

// File: rtl/tod_bcd_clock_chk.sv
module tod_bcd_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_n,
  input logic       sec_tick,
  input logic       min_set_n,
  input logic       hr_set_n,
  input logic [6:0] sec_bcd,
  input logic [6:0] min_bcd,
  input logic [5:0] hr_bcd,
  input logic       chime,
  input logic       sec_wrap,
  input logic       min_carry,
  input logic       hr_step
);

  p_legal_digits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bcd[3:0] <= 4'd9 && sec_bcd[6:4] <= 3'd5 &&
    min_bcd[3:0] <= 4'd9 && min_bcd[6:4] <= 3'd5 &&
    hr_bcd[3:0] <= 4'd9 && hr_bcd < 6'h24);

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (sec_bcd == 7'h00 && min_bcd == 7'h00 && hr_bcd == 6'h00 && !chime));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !sec_tick) |=> ($stable(sec_bcd) && $stable(min_bcd) &&
                             $stable(hr_bcd) && $stable(chime)));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && sec_wrap) |=> (sec_bcd == 7'h00));

  p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && min_carry && hr_set_n && hr_bcd == 6'h23) |=> (hr_bcd == 6'h00 && min_bcd == 7'h00));

  p_minset_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && sec_tick && !min_set_n && hr_set_n) |=> $stable(hr_bcd));

  p_hrset_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && hr_step) |=> !$stable(hr_bcd));

  p_chime_on_hour_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chime) |-> (sec_bcd == 7'h00 && min_bcd == 7'h00));

  p_set_no_chime_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && sec_tick && !min_set_n && !chime) |=> !chime);

endmodule

bind tod_bcd_clock tod_bcd_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sec_tick(sec_tick),
  .min_set_n(min_set_n), .hr_set_n(hr_set_n), .sec_bcd(sec_bcd),
  .min_bcd(min_bcd), .hr_bcd(hr_bcd), .chime(chime),
  .sec_wrap(sec_wrap), .min_carry(min_carry), .hr_step(hr_step));

// File: tb/tb_tod_bcd_clock.sv
module tb_tod_bcd_clock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1;
  logic       sec_tick = 1'b0;
  logic       min_set_n = 1'b1;
  logic       hr_set_n = 1'b1;
  logic [6:0] sec_bcd, min_bcd;
  logic [5:0] hr_bcd;
  logic       chime;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // reference state, plain decimal
  int mh = 0, mm = 0, ms = 0, mc = 0;
  localparam int CHIME_LEN = 5;

  logic [20:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tod_bcd_clock dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sec_tick(sec_tick),
    .min_set_n(min_set_n), .hr_set_n(hr_set_n), .sec_bcd(sec_bcd),
    .min_bcd(min_bcd), .hr_bcd(hr_bcd), .chime(chime));

  function automatic logic [6:0] enc(input int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [20:0] expected();
    logic [6:0] h7;
    h7 = enc(mh);
    return {h7[5:0], enc(mm), enc(ms), 1'(mc != 0)};
  endfunction

  task automatic model_zero();
    mh = 0; mm = 0; ms = 0; mc = 0;
  endtask

  task automatic model_tick();
    bit roll_s, roll_m, start;
    roll_s = (ms == 59);
    roll_m = (mm == 59);
    start  = min_set_n && roll_s && roll_m;
    ms = (ms + 1) % 60;
    if (!min_set_n || roll_s) mm = (mm + 1) % 60;
    if (!hr_set_n || start)   mh = (mh + 1) % 24;
    if (start)       mc = CHIME_LEN;
    else if (mc > 0) mc = mc - 1;
  endtask

  task automatic push(input string tag);
    exp_q.push_back(expected());
    tag_q.push_back(tag);
  endtask

  // driver: called at a falling edge
  task automatic tick(input string tag);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    model_tick();
    push(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    push(tag);
  endtask

  task automatic clear_with_tick(input string tag);
    clr_n = 1'b0;
    sec_tick = 1'b1;
    @(negedge clk);
    clr_n = 1'b1;
    sec_tick = 1'b0;
    model_zero();
    push(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [20:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {hr_bcd, min_bcd, sec_bcd, chime};
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: got hr=%h min=%h sec=%h chime=%b, expected hr=%h min=%h sec=%h chime=%b",
                 t, a[20:15], a[14:8], a[7:1], a[0], e[20:15], e[14:8], e[7:1], e[0]);
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_zero();
    idle("R1 reset");
    for (int i = 0; i < 4; i++) idle("R2 idle");

    // R3: 09->10 and 59->00 with carry into minutes; R5 digit layout
    for (int i = 0; i < 12; i++) tick("R3 R5 seconds");
    for (int i = 0; i < 50; i++) tick("R3 seconds wrap");
    for (int i = 0; i < 3; i++) idle("R2 idle");

    // R6: minute set, wrap without hour carry, chime stays low (R9)
    min_set_n = 1'b0;
    for (int i = 0; i < 62; i++) tick("R6 R9 minute set");
    min_set_n = 1'b1;

    // R7: hour set through 09->10, 23->00, back to 23
    hr_set_n = 1'b0;
    for (int i = 0; i < 47; i++) tick("R7 hour set");
    hr_set_n = 1'b1;

    // bring to 23:59:50 then cross midnight: R4 and chime R8
    min_set_n = 1'b0;
    while (mm != 59) tick("R6 minute set");
    min_set_n = 1'b1;
    while (ms != 50) tick("R3 seconds");
    for (int i = 0; i < 20; i++) tick("R4 R8 midnight");

    // R9: set-driven minute rollover never chimes
    min_set_n = 1'b0;
    while (mm != 59) tick("R6 minute set");
    for (int i = 0; i < 3; i++) tick("R9 set rollover");
    min_set_n = 1'b1;

    // mid-day hour crossing: R8 chime length
    begin
      int h0;
      h0 = mh;
      while (mh == h0) tick("R8 hour crossing");
    end
    for (int i = 0; i < 2; i++) tick("R8 chime window");

    // clear during chime, with a tick present
    clear_with_tick("R1 clear priority");
    idle("R1 after clear");
    tick("R1 first tick after clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule